// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block drives the bit clock and the frame clock of an audio serial port when the port is clock master. It derives both clocks from one reference clock in two stages. A programmable pre-divider comes first and offers ratios of 1, 1.5, 2, 3 and 4. A speed-mode divider follows it. The bit clock always runs at 64 times the frame rate. The frame clock is high for 32 bit-clock periods and low for 32. Both outputs are flip-flops clocked by the reference, so the port logic downstream stays in one clock domain.

The reference clock `clk_i` runs at twice the nominal master-clock rate. This makes every half period of the bit clock an integer or a regular enable pattern of reference cycles. With pre-divide ratio P and speed ratio S, one bit-clock period lasts S·P master-clock periods, which is 2·S·P cycles of `clk_i`. One frame lasts 128·S·P cycles of `clk_i`. New select values are sampled only at the start of a frame, so a select change never cuts a clock pulse short. Two strobes, each one cycle wide, mark every falling edge of the bit clock and every frame start.

Top module: `audio_mclkgen`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `lrck_o`, `bit_tick_o` and `frame_tick_o` are all 0.
- R2: With pre-divide ratio P and speed ratio S in force, the `sclk_o` period is 2·S·P cycles of `clk_i`.
- R3: A frame is 64 `sclk_o` periods (128·S·P cycles of `clk_i`). Within it, `lrck_o` is low for 32 `sclk_o` periods and then high for 32.
- R4: `pre_sel_i` selects P: 3'b000 gives 1, 3'b001 gives 1.5, 3'b010 gives 2, 3'b011 gives 3 and 3'b100 gives 4. P = 1.5 is built from an enable that fires on two of every three `clk_i` cycles.
- R5: `spd_sel_i` selects S: 2'b00 gives 4 (frame = 256·P master periods), 2'b01 gives 2 and 2'b10 gives 1.
- R6: The reserved codes `pre_sel_i` 3'b101 to 3'b111 act as 3'b000, and `spd_sel_i` 2'b11 acts as 2'b00.
- R7: `lrck_o` changes level only in a cycle where `sclk_o` goes from 1 to 0.
- R8: Select inputs are sampled only in the first cycle after reset and in the cycle in which `lrck_o` falls (the frame start). A change at any other time does not alter the frame in progress.
- R9: `bit_tick_o` is 1 exactly in the cycles where `sclk_o` has just fallen. `frame_tick_o` is 1 exactly in the cycles where `lrck_o` has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at twice the master-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_sel_i | input | 3 | Pre-divide select |
| spd_sel_i | input | 2 | Speed-mode select |
| lrck_o | output | 1 | Frame clock |
| sclk_o | output | 1 | Bit clock |
| bit_tick_o | output | 1 | Strobe in the cycle after a bit-clock falling edge is registered |
| frame_tick_o | output | 1 | Strobe at each frame start |

## Verification
The hardest case to reach is a select change that arrives in the middle of a frame. The inputs only matter at one cycle per frame, so a faulty design that samples them early shows up only if the bench changes them well away from that cycle and then checks the length of the frame that was already running. The bench first lets a short frame settle. It then switches to a long configuration twenty cycles after a frame start. It requires the frame in progress to keep its old length and the frame after it to take the new one. The fractional ratio of 1.5 with speed ratio 1 is also exercised, because that pairing gives the irregular enable pattern together with the shortest bit clock.

// File: rtl/amcg_pkg.sv
package amcg_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10
  } spd_e;

  typedef struct packed {
    logic [2:0] pre;
    spd_e       spd;
  } cfg_t;

  localparam int PRE_CW = 2;
  localparam int SPD_CW = 2;

  function automatic logic [2:0] norm_pre(input logic [2:0] c);
    return (c > 3'd4) ? 3'd0 : c;
  endfunction

  function automatic spd_e norm_spd(input logic [1:0] c);
    return (c == 2'b11) ? SPD_SINGLE : spd_e'(c);
  endfunction

  // last count of the pre-divider counter
  function automatic logic [PRE_CW-1:0] pre_last(input logic [2:0] c);
    case (c)
      3'd1:    return PRE_CW'(2);
      3'd2:    return PRE_CW'(1);
      3'd3:    return PRE_CW'(2);
      3'd4:    return PRE_CW'(3);
      default: return PRE_CW'(0);
    endcase
  endfunction

  // enables per half bit-clock period, minus one
  function automatic logic [SPD_CW-1:0] spd_last(input spd_e s);
    case (s)
      SPD_DOUBLE: return SPD_CW'(1);
      SPD_QUAD:   return SPD_CW'(0);
      default:    return SPD_CW'(3);
    endcase
  endfunction
endpackage

// File: rtl/amcg_prediv.sv
module amcg_prediv
  import amcg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       hold_i,
  input  logic [2:0] pre_code_i,
  output logic       en_o
);
  logic [PRE_CW-1:0] cnt_q;
  logic [PRE_CW-1:0] last;
  logic              frac;

  always_comb begin
    last = pre_last(pre_code_i);
    frac = (pre_code_i == 3'd1);
    en_o = !hold_i && (frac ? (cnt_q != '0) : (cnt_q == last));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (cnt_q == last) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // back-to-back enables only for ratio 1 or the 1.5 pattern
  AST_PRE_EN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o) && !$past(clr_i)) |-> (frac || last == '0)); // R4
endmodule

// File: rtl/amcg_bitframe.sv
module amcg_bitframe
  import amcg_pkg::*;
#(
  parameter int HALF_BITS = 32,
  localparam int BW = $clog2(HALF_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [SPD_CW-1:0] spd_last_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              bit_tick_o,
  output logic              frame_tick_o,
  output logic              frame_evt_o
);
  logic [SPD_CW-1:0] hb_q;
  logic [BW-1:0]     bit_q;
  logic              sclk_q, lrck_q, btick_q, ftick_q;
  logic              tog, fall, lr_tog;

  always_comb begin
    tog         = en_i && (hb_q == spd_last_i);
    fall        = tog && sclk_q;
    lr_tog      = fall && (bit_q == BW'(HALF_BITS - 1));
    frame_evt_o = lr_tog && lrck_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q    <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      lrck_q  <= 1'b0;
      btick_q <= 1'b0;
      ftick_q <= 1'b0;
    end else begin
      if (clr_i || tog) hb_q <= '0;
      else if (en_i)    hb_q <= hb_q + 1'b1;
      if (tog) sclk_q <= ~sclk_q;
      if (lr_tog)    bit_q <= '0;
      else if (fall) bit_q <= bit_q + 1'b1;
      if (lr_tog) lrck_q <= ~lrck_q;
      btick_q <= fall;
      ftick_q <= frame_evt_o;
    end
  end

  assign sclk_o       = sclk_q;
  assign lrck_o       = lrck_q;
  assign bit_tick_o   = btick_q;
  assign frame_tick_o = ftick_q;

  AST_LR_ON_SCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_q != $past(lrck_q)) |-> ($past(sclk_q) && !sclk_q)); // R7
  AST_BIT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btick_q |-> ($past(sclk_q) && !sclk_q)); // R9
  AST_FRAME_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftick_q |-> ($past(lrck_q) && !lrck_q)); // R9
endmodule

// File: rtl/audio_mclkgen.sv
module audio_mclkgen
  import amcg_pkg::*;
#(
  parameter int HALF_BITS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] pre_sel_i,
  input  logic [1:0] spd_sel_i,
  output logic       lrck_o,
  output logic       sclk_o,
  output logic       bit_tick_o,
  output logic       frame_tick_o
);
  cfg_t cfg_q;
  logic init_q;
  logic pre_en, frame_evt, load;

  assign load = init_q || frame_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      cfg_q  <= '{pre: 3'd0, spd: SPD_SINGLE};
    end else begin
      init_q <= 1'b0;
      if (load) begin
        cfg_q.pre <= norm_pre(pre_sel_i);
        cfg_q.spd <= norm_spd(spd_sel_i);
      end
    end
  end

  amcg_prediv u_prediv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load),
    .hold_i     (init_q),
    .pre_code_i (cfg_q.pre),
    .en_o       (pre_en)
  );

  amcg_bitframe #(.HALF_BITS(HALF_BITS)) u_bitframe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (pre_en),
    .clr_i        (load),
    .spd_last_i   (spd_last(cfg_q.spd)),
    .sclk_o       (sclk_o),
    .lrck_o       (lrck_o),
    .bit_tick_o   (bit_tick_o),
    .frame_tick_o (frame_tick_o),
    .frame_evt_o  (frame_evt)
  );

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(cfg_q)); // R8
endmodule

// File: tb/audio_mclkgen_tb.sv
module audio_mclkgen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] pre_sel_i = 3'd0;
  logic [1:0] spd_sel_i = 2'd0;
  logic       lrck_o, sclk_o, bit_tick_o, frame_tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  audio_mclkgen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_sel_i(pre_sel_i), .spd_sel_i(spd_sel_i),
    .lrck_o(lrck_o), .sclk_o(sclk_o), .bit_tick_o(bit_tick_o), .frame_tick_o(frame_tick_o)
  );

  // {pre[2:0], spd[1:0], sclk period[5:0], frame[11:0]}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 2'd0, 6'd8,  12'd512},
    {3'd1, 2'd0, 6'd12, 12'd768},
    {3'd2, 2'd1, 6'd8,  12'd512},
    {3'd3, 2'd2, 6'd6,  12'd384},
    {3'd4, 2'd0, 6'd32, 12'd2048},
    {3'd1, 2'd2, 6'd3,  12'd192},
    {3'd4, 2'd1, 6'd16, 12'd1024},
    {3'd3, 2'd1, 6'd12, 12'd768},
    {3'd0, 2'd2, 6'd2,  12'd128},
    {3'd5, 2'd0, 6'd8,  12'd512},
    {3'd0, 2'd3, 6'd8,  12'd512},
    {3'd7, 2'd3, 6'd8,  12'd512}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // continuous edge/strobe relations, sampled at negedge
  logic pl = 1'b0, ps = 1'b0;
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (lrck_o != pl) chk("R7 lrck moves on sclk fall", int'(ps && !sclk_o), 1);
      if (bit_tick_o || (ps && !sclk_o)) chk("R9 bit_tick", int'(bit_tick_o), int'(ps && !sclk_o));
      if (frame_tick_o || (pl && !lrck_o)) chk("R9 frame_tick", int'(frame_tick_o), int'(pl && !lrck_o));
    end
    pl = lrck_o;
    ps = sclk_o;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_fall();
    logic p;
    p = lrck_o;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      if (p && !lrck_o) return;
      p = lrck_o;
    end
  endtask

  task automatic measure(output int frame, output int hi, output int per, output int rises);
    logic pl2, ps2;
    int r1, r2;
    pl2 = lrck_o; ps2 = sclk_o;
    frame = 0; hi = 0; rises = 0; r1 = -1; r2 = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      frame++;
      if (lrck_o) hi++;
      if (!ps2 && sclk_o) begin
        rises++;
        if (r1 < 0) r1 = frame; else if (r2 < 0) r2 = frame;
      end
      if (pl2 && !lrck_o) break;
      pl2 = lrck_o; ps2 = sclk_o;
    end
    per = r2 - r1;
  endtask

  initial begin
    int fr, hi, per, rs;
    string tag;
    repeat (3) @(negedge clk_i);
    chk("R1 lrck in reset", int'(lrck_o), 0);
    chk("R1 sclk in reset", int'(sclk_o), 0);
    chk("R1 bit_tick in reset", int'(bit_tick_o), 0);
    chk("R1 frame_tick in reset", int'(frame_tick_o), 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      pre_sel_i = VEC[v][22:20];
      spd_sel_i = VEC[v][19:18];
      wait_fall();
      measure(fr, hi, per, rs);
      tag = (v >= 9) ? "R6" : "R4/R5";
      chk({tag, " R3 frame length"}, fr, int'(VEC[v][11:0]));
      chk({tag, " R3 lrck high half"}, hi, int'(VEC[v][11:0]) / 2);
      chk({tag, " R2 sclk period"}, per, int'(VEC[v][17:12]));
      chk("R3 sclk periods per frame", rs, 64);
    end

    // R8: mid-frame change must not alter the running frame
    @(negedge clk_i);
    pre_sel_i = 3'd0; spd_sel_i = 2'd2;
    wait_fall();
    wait_fall();
    repeat (20) @(negedge clk_i);
    pre_sel_i = 3'd4; spd_sel_i = 2'd0;
    fr = 20;
    begin
      int f2, h2, p2, r2;
      measure(f2, h2, p2, r2);
      chk("R8 running frame keeps old length", fr + f2, 128);
      measure(f2, h2, p2, r2);
      chk("R8 next frame takes new length", f2, 2048);
    end

    // R1: reset during operation, then config sampled after release
    @(negedge clk_i);
    pre_sel_i = 3'd1; spd_sel_i = 2'd1;
    repeat (37) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 lrck after reset", int'(lrck_o), 0);
    chk("R1 sclk after reset", int'(sclk_o), 0);
    chk("R1 ticks after reset", int'(bit_tick_o | frame_tick_o), 0);
    rst_ni = 1'b1;
    wait_fall();
    measure(fr, hi, per, rs);
    chk("R8 select sampled after reset", fr, 384);
    chk("R2 sclk period after reset", per, 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule